// File: doc/BRIEF.md
# Clock Output Bank Gating and Level Control

This block sits between the output dividers of a multi-output clock synthesizer and its pad drivers. Each of the four banks receives a divided clock, and bank 0 can also receive the raw reference clock for PLL bypass. For every bank the block drives two logical lines, A and B, with either a toggling pattern or a fixed idle pattern. It also reports the output type that is currently in effect, so that the drivers can be set up to match. In this digital model every source clock is a level, sampled on the system clock `clk`. The outputs are formed from registered state only.

Each bank runs its own four-state machine:

- **PARK** is the state after reset and the state a bank enters when the sequencer requests a park. It drives A low and B high whatever the type.
- **RUN** toggles the lines from the source clock.
- **OFF** is the disabled state. Its idle pattern depends on the type:

| Applied type | A | B |
|---|---|---|
| Differential (`type_se` bit = 0) | low | high |
| Single-ended (`type_se` bit = 1) | low | low |

- **DOWN** is forced by power-down and drives both lines low.

The transitions are:

- **PARK→RUN**: the park request is released and the bank is enabled.
- **PARK→OFF**: the park request is released and the bank is disabled.
- **RUN→PARK** and **OFF→PARK**: a park request arrives.
- **RUN→OFF**: the enable is dropped.
- **OFF→RUN**: the enable is raised.
- **any→DOWN**: power-down is asserted.
- **DOWN→PARK**: power-down is released.

Every transition except those into and out of DOWN is taken only while the registered source level is low. The output type is captured only while the bank is in PARK or DOWN. For bank 0, the choice between the reference and the divided clock is also captured only in those states.

Top module: `clkout_bank_gate`

## Requirements
- R1: While reset is asserted, every bank is in PARK and drives A=0, B=1, and `type_flag` reads 0 for every bank.
- R2: A bank in PARK drives A=0, B=1 whatever output type is selected.
- R3: A disabled bank with the differential type (applied type bit 0) drives A=0, B=1.
- R4: A disabled bank with the single-ended type (applied type bit 1) drives A=0, B=0.
- R5: A running differential bank drives A equal to its source level, registered once (one `clk` cycle of latency), and drives B as the inverse of A.
- R6: A running single-ended bank drives A and B both equal to its registered source level.
- R7: A move into or out of PARK or OFF takes effect only on a clock edge at which the registered source level is low. A high level that is in progress is therefore never cut short.
- R8: The `type_se` bit is applied only while the bank is in PARK or DOWN. A change requested while the bank is running is held until the next park, and `type_flag` shows the type currently applied.
- R9: When bypass is selected, bank 0 follows `ref_clk` instead of its divided clock. The bypass select is captured only while bank 0 is in PARK or DOWN. The other banks always follow their own divided clocks.
- R10: Asserting `pwr_down` drives A=0, B=0 on every bank from the next cycle, whatever the source levels. On release, every bank returns to PARK at the next edge.
- R11: Each bank's state and outputs depend only on that bank's own controls and source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| div_clk | input | NB | Divided clock level for each bank |
| ref_clk | input | 1 | Reference clock level, used by bank 0 in bypass |
| bypass | input | 1 | Bypass request for bank 0 (1 = follow `ref_clk`) |
| type_se | input | NB | Requested output type per bank (1 = single-ended, 0 = differential) |
| out_en | input | NB | Enable per bank |
| park_req | input | NB | Park request per bank from the sequencer |
| pwr_down | input | 1 | Forces all banks into DOWN |
| out_a | output | NB | Line A per bank |
| out_b | output | NB | Line B per bank |
| type_flag | output | NB | Output type currently applied per bank |

## Verification
The bench drops an enable and a park request while the source is high. A design without gating would then cut the high phase short: A would fall one cycle early. It changes a bank's type while the bank runs and then disables it. A design that applied the type at once would show the differential idle pattern and flip `type_flag` instead of driving both lines low. It flips the bypass select while bank 0 runs, which a design with an ungated select would switch to the divided clock in mid-stream. It also asserts power-down with all sources high, which a design that treated power-down as a gated park would not honour at once.

// File: rtl/ob_pkg.sv
package ob_pkg;
    typedef enum logic [1:0] {
        S_PARK = 2'd0,
        S_RUN  = 2'd1,
        S_OFF  = 2'd2,
        S_DOWN = 2'd3
    } bank_st_t;

    localparam logic TYPE_DIFF = 1'b0;
    localparam logic TYPE_SE   = 1'b1;
endpackage

// File: rtl/ob_src_sel.sv
module ob_src_sel #(
    parameter bit HAS_BYP = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic div_clk,
    input  logic ref_clk,
    input  logic byp_req,
    input  logic cfg_open,
    output logic src_q
);
    logic src_d;

    generate
        if (HAS_BYP) begin : g_byp
            logic byp_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)        byp_q <= 1'b0;
                else if (cfg_open) byp_q <= byp_req;
            end
            assign src_d = byp_q ? ref_clk : div_clk;
        end else begin : g_plain
            logic unused_sel;
            assign unused_sel = ^{ref_clk, byp_req, cfg_open};
            assign src_d = div_clk;
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) src_q <= 1'b0;
        else        src_q <= src_d;
    end
endmodule

// File: rtl/ob_bank_fsm.sv
module ob_bank_fsm
    import ob_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     src_q,
    input  logic     park_req,
    input  logic     en,
    input  logic     pwr_down,
    input  logic     type_req,
    output bank_st_t st_q,
    output logic     type_q,
    output logic     cfg_open
);
    bank_st_t st_d;

    assign cfg_open = (st_q == S_PARK) || (st_q == S_DOWN);

    always_comb begin
        st_d = st_q;
        if (pwr_down) begin
            st_d = S_DOWN;
        end else begin
            unique case (st_q)
                S_DOWN: st_d = S_PARK;
                S_PARK: if (!park_req && !src_q) st_d = en ? S_RUN : S_OFF;
                S_RUN: begin
                    if (!src_q) begin
                        if (park_req) st_d = S_PARK;
                        else if (!en) st_d = S_OFF;
                    end
                end
                S_OFF: begin
                    if (!src_q) begin
                        if (park_req) st_d = S_PARK;
                        else if (en)  st_d = S_RUN;
                    end
                end
                default: st_d = S_PARK;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= S_PARK;
            type_q <= TYPE_DIFF;
        end else begin
            st_q <= st_d;
            if (cfg_open) type_q <= type_req;
        end
    end
endmodule

// File: rtl/ob_level_map.sv
module ob_level_map
    import ob_pkg::*;
(
    input  bank_st_t st,
    input  logic     type_q,
    input  logic     src_q,
    output logic     line_a,
    output logic     line_b
);
    always_comb begin
        unique case (st)
            S_RUN: begin
                line_a = src_q;
                line_b = (type_q == TYPE_SE) ? src_q : ~src_q;
            end
            S_OFF: begin
                line_a = 1'b0;
                line_b = (type_q == TYPE_DIFF);
            end
            S_DOWN: begin
                line_a = 1'b0;
                line_b = 1'b0;
            end
            default: begin
                line_a = 1'b0;
                line_b = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/clkout_bank_gate.sv
module clkout_bank_gate
    import ob_pkg::*;
#(
    parameter int NB       = 4,
    parameter int BYP_BANK = 0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] div_clk,
    input  logic          ref_clk,
    input  logic          bypass,
    input  logic [NB-1:0] type_se,
    input  logic [NB-1:0] out_en,
    input  logic [NB-1:0] park_req,
    input  logic          pwr_down,
    output logic [NB-1:0] out_a,
    output logic [NB-1:0] out_b,
    output logic [NB-1:0] type_flag
);
    localparam int LAST_BANK = NB - 1;

    bank_st_t [NB-1:0] st_w;
    logic     [NB-1:0] src_q_w;
    logic     [NB-1:0] open_w;

    generate
        for (genvar i = 0; i <= LAST_BANK; i++) begin : g_bank
            ob_src_sel #(.HAS_BYP(i == BYP_BANK)) u_src (
                .clk      (clk),
                .rst_n    (rst_n),
                .div_clk  (div_clk[i]),
                .ref_clk  (ref_clk),
                .byp_req  (bypass),
                .cfg_open (open_w[i]),
                .src_q    (src_q_w[i])
            );

            ob_bank_fsm u_fsm (
                .clk      (clk),
                .rst_n    (rst_n),
                .src_q    (src_q_w[i]),
                .park_req (park_req[i]),
                .en       (out_en[i]),
                .pwr_down (pwr_down),
                .type_req (type_se[i]),
                .st_q     (st_w[i]),
                .type_q   (type_flag[i]),
                .cfg_open (open_w[i])
            );

            ob_level_map u_map (
                .st     (st_w[i]),
                .type_q (type_flag[i]),
                .src_q  (src_q_w[i]),
                .line_a (out_a[i]),
                .line_b (out_b[i])
            );
        end
    endgenerate
endmodule

// File: rtl/ob_gate_chk.sv
module ob_gate_chk
    import ob_pkg::*;
#(
    parameter int NB = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pwr_down,
    input logic [NB-1:0]     park_req,
    input logic [NB-1:0]     out_a,
    input logic [NB-1:0]     out_b,
    input logic [NB-1:0]     type_flag,
    input logic [NB-1:0]     src_q,
    input bank_st_t [NB-1:0] st
);
    // R10
    pdown_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> (out_a == '0 && out_b == '0));

    generate
        for (genvar i = 0; i < NB; i++) begin : g_chk
            // R7
            no_runt_chk: assert property (@(posedge clk) disable iff (!rst_n)
                ($fell(out_a[i]) && !$past(pwr_down)) |-> !src_q[i]);

            // R8
            type_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (st[i] == S_RUN && $past(st[i]) == S_RUN) |-> $stable(type_flag[i]));

            // R2
            park_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (park_req[i] && !src_q[i] && !pwr_down && st[i] != S_DOWN)
                |=> (out_a[i] == 1'b0 && out_b[i] == 1'b1));
        end
    endgenerate
endmodule

bind clkout_bank_gate ob_gate_chk #(.NB(NB)) u_gate_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_down  (pwr_down),
    .park_req  (park_req),
    .out_a     (out_a),
    .out_b     (out_b),
    .type_flag (type_flag),
    .src_q     (src_q_w),
    .st        (st_w)
);

// File: tb/clkout_bank_gate_tb_top.sv
module clkout_bank_gate_tb_top;
    localparam int NB = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NB-1:0] div_clk;
    logic          ref_clk;
    logic          bypass;
    logic [NB-1:0] type_se;
    logic [NB-1:0] out_en;
    logic [NB-1:0] park_req;
    logic          pwr_down;
    logic [NB-1:0] out_a;
    logic [NB-1:0] out_b;
    logic [NB-1:0] type_flag;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    clkout_bank_gate #(.NB(NB)) dut_i (
        .clk(clk), .rst_n(rst_n), .div_clk(div_clk), .ref_clk(ref_clk),
        .bypass(bypass), .type_se(type_se), .out_en(out_en),
        .park_req(park_req), .pwr_down(pwr_down), .out_a(out_a),
        .out_b(out_b), .type_flag(type_flag)
    );

    task automatic step();
        @(posedge clk);
        #5;
    endtask

    task automatic chk_ab(input int bank, input logic ea, input logic eb, input string req);
        n_vec++;
        if (out_a[bank] !== ea || out_b[bank] !== eb) begin
            n_fail++;
            $display("FAIL %s bank %0d: A/B = %b/%b, expected %b/%b",
                     req, bank, out_a[bank], out_b[bank], ea, eb);
        end
    endtask

    task automatic chk_vec(input logic [NB-1:0] act, input logic [NB-1:0] exp, input string req);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b, expected %b", req, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0; div_clk = '0; ref_clk = 1'b0; bypass = 1'b0;
        type_se = '0; out_en = '1; park_req = '1; pwr_down = 1'b0;
        step(); step();
        chk_vec(out_a, '0, "R1 A lines");
        chk_vec(out_b, '1, "R1 B lines");
        chk_vec(type_flag, '0, "R1 type");
    endtask

    task automatic t_run();
        rst_n = 1'b1; park_req = '0; type_se = 4'b0010;
        step();
        chk_ab(0, 1'b0, 1'b1, "R5 low phase");
        chk_ab(1, 1'b0, 1'b0, "R6 low phase");
        chk_vec(type_flag, 4'b0010, "R8 type applied");
        div_clk = '1;
        step();
        chk_ab(0, 1'b1, 1'b0, "R5 high phase");
        chk_ab(1, 1'b1, 1'b1, "R6 high phase");
        chk_ab(2, 1'b1, 1'b0, "R5 bank2");
        chk_ab(3, 1'b1, 1'b0, "R11 bank3");
    endtask

    task automatic t_gate();
        park_req = 4'b0001; out_en = 4'b1011;
        step();
        chk_ab(0, 1'b1, 1'b0, "R7 park held while high");
        chk_ab(2, 1'b1, 1'b0, "R7 disable held while high");
        div_clk = '0;
        step();
        step();
        div_clk = '1;
        step();
        chk_ab(0, 1'b0, 1'b1, "R2 parked");
        chk_ab(2, 1'b0, 1'b1, "R3 diff disabled");
        chk_ab(3, 1'b1, 1'b0, "R11 bank3 unaffected");
        chk_ab(1, 1'b1, 1'b1, "R6 bank1 running");
    endtask

    task automatic t_type();
        type_se = 4'b0000;
        step();
        chk_vec(type_flag, 4'b0010, "R8 type held while running");
        chk_ab(1, 1'b1, 1'b1, "R8 still single-ended");
        div_clk = '0; out_en = 4'b1001;
        step();
        step();
        div_clk = '1;
        step();
        chk_ab(1, 1'b0, 1'b0, "R4 single-ended disabled");
        chk_vec(type_flag, 4'b0010, "R8 type held while off");
        park_req = 4'b0011; div_clk = '0;
        step(); step(); step();
        chk_vec(type_flag, 4'b0000, "R8 type applied after park");
        chk_ab(1, 1'b0, 1'b1, "R2 parked bank1");
    endtask

    task automatic t_byp();
        bypass = 1'b1; ref_clk = 1'b0;
        step();
        park_req = 4'b0010;
        step();
        chk_ab(0, 1'b0, 1'b1, "R9 running low");
        ref_clk = 1'b1;
        step();
        chk_ab(0, 1'b1, 1'b0, "R9 follows reference");
        chk_ab(3, 1'b0, 1'b1, "R9 bank3 ignores reference");
        bypass = 1'b0; ref_clk = 1'b0; div_clk = '1;
        step();
        chk_ab(0, 1'b0, 1'b1, "R9 bypass change held");
        chk_ab(3, 1'b1, 1'b0, "R9 bank3 follows divider");
    endtask

    task automatic t_pdown();
        pwr_down = 1'b1; ref_clk = 1'b1; div_clk = '1;
        step();
        chk_vec(out_a, '0, "R10 A off");
        chk_vec(out_b, '0, "R10 B off");
        pwr_down = 1'b0;
        step();
        chk_vec(out_a, '0, "R10 A parked after release");
        chk_vec(out_b, '1, "R10 B parked after release");
    endtask

    initial begin
        t_reset();
        t_run();
        t_gate();
        t_type();
        t_byp();
        t_pdown();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end
endmodule